// File: doc/BRIEF.md
# Next Program Counter Unit

This block holds the program counter of a simple 32-bit pipeline and, every clock cycle, selects the address of the following instruction. The choice depends on a small control code from the decoder, a 16-bit signed branch displacement, a 26-bit jump field, a register value, and two register operands that are compared inside the block. Branch targets are counted in instructions relative to the sequential successor. Direct jumps take their upper address bits from the region of that successor. Register jumps go to the register value.

The unit also drives the return-address write for subroutine calls. It provides the address to store, the destination register index and a write enable. The conditional linking branches raise that enable only when their condition holds. The two jump-and-link forms always raise it.

Top module: `npc_unit`

## Requirements
- R1: A synchronous active-high reset loads `pc` with the parameter START_ADDR. Reset takes priority over any flow code.
- R2: Flow code 0 (sequential) makes `pc_next` equal to `pc`+4. `redirect` and `link_we` are both 0.
- R3: A conditional branch whose condition holds goes to `pc`+4 plus the sign-extended displacement shifted left by two. If the condition fails, it goes to `pc`+4.
- R4: Flow code 1 branches when `cmp_a` equals `cmp_b`. Flow code 2 branches when they differ.
- R5: Flow codes 3, 4, 5 and 6 branch when `cmp_a`, read as two's complement, is ≥0, >0, ≤0 and <0 respectively.
- R6: Flow code 7 (≥0) and flow code 8 (<0) are linking branches. They raise `link_we` only when taken, with `link_sel`=31 and `link_addr`=`pc`+4.
- R7: Flow code 9 jumps to {(`pc`+4)[31:28], `jump_field`, 2'b00}.
- R8: Flow code 10 jumps like code 9. It always raises `link_we` with `link_sel`=31 and `link_addr`=`pc`+4.
- R9: Flow code 11 jumps to `rs_value`. Flow code 12 does the same and always raises `link_we`, with `link_sel`=`rd_sel` and `link_addr`=`pc`+4.
- R10: `redirect` is 1 exactly when `pc_next` comes from a taken branch or any jump. For flow codes other than 12, `link_sel` is 31.
- R11: Flow codes 13 to 15 behave as code 0. Inputs that the current code does not use have no effect on `pc_next` or on the link outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flow_kind | input | 4 | Control-flow code from the decoder |
| br_offset | input | 16 | Signed branch displacement in instructions |
| jump_field | input | 26 | Word address field of a direct jump |
| rs_value | input | 32 | Register contents used by register jumps |
| cmp_a | input | 32 | First compare operand |
| cmp_b | input | 32 | Second compare operand (equality tests only) |
| rd_sel | input | 5 | Link destination for register jump-and-link |
| pc | output | 32 | Current program counter |
| pc_next | output | 32 | Address loaded into `pc` at the next edge |
| redirect | output | 1 | Next address is not the sequential one |
| link_we | output | 1 | Return-address write enable |
| link_sel | output | 5 | Return-address destination register |
| link_addr | output | 32 | Return address (`pc`+4) |

## Verification
The bench keeps the default widths and builds the unit with START_ADDR = 0x0FFF_FFF0, so the program counter reaches the last word of a 256 MB region after three sequential steps. The direct jump that follows must take its top four bits from the next region, reached through `pc`+4 and not through `pc`. A later branch with the most negative displacement carries the address back across that boundary. A directed branch with the largest positive displacement tests the sign extension at its other extreme.

// File: rtl/npc_pkg.sv
package npc_pkg;

    typedef enum logic [3:0] {
        FK_SEQ        = 4'd0,
        FK_BR_EQ      = 4'd1,
        FK_BR_NE      = 4'd2,
        FK_BR_GEZ     = 4'd3,
        FK_BR_GTZ     = 4'd4,
        FK_BR_LEZ     = 4'd5,
        FK_BR_LTZ     = 4'd6,
        FK_BR_GEZ_LNK = 4'd7,
        FK_BR_LTZ_LNK = 4'd8,
        FK_JMP        = 4'd9,
        FK_JMP_LNK    = 4'd10,
        FK_JREG       = 4'd11,
        FK_JREG_LNK   = 4'd12
    } flow_kind_e;

    typedef enum logic [1:0] {
        SRC_SEQ,
        SRC_BRANCH,
        SRC_DIRECT,
        SRC_REG
    } pc_src_e;

    typedef enum logic [2:0] {
        CMP_NONE,
        CMP_EQ,
        CMP_NE,
        CMP_GEZ,
        CMP_GTZ,
        CMP_LEZ,
        CMP_LTZ
    } cmp_op_e;

    typedef struct packed {
        pc_src_e src;
        cmp_op_e cmp;
        logic    link_always;
        logic    link_on_taken;
        logic    link_to_rd;
    } flow_ctl_t;

    function automatic flow_ctl_t decode_flow(input logic [3:0] code);
        flow_ctl_t c;
        c = '{src: SRC_SEQ, cmp: CMP_NONE, link_always: 1'b0,
              link_on_taken: 1'b0, link_to_rd: 1'b0};
        case (flow_kind_e'(code))
            FK_BR_EQ:      begin c.src = SRC_BRANCH; c.cmp = CMP_EQ;  end
            FK_BR_NE:      begin c.src = SRC_BRANCH; c.cmp = CMP_NE;  end
            FK_BR_GEZ:     begin c.src = SRC_BRANCH; c.cmp = CMP_GEZ; end
            FK_BR_GTZ:     begin c.src = SRC_BRANCH; c.cmp = CMP_GTZ; end
            FK_BR_LEZ:     begin c.src = SRC_BRANCH; c.cmp = CMP_LEZ; end
            FK_BR_LTZ:     begin c.src = SRC_BRANCH; c.cmp = CMP_LTZ; end
            FK_BR_GEZ_LNK: begin c.src = SRC_BRANCH; c.cmp = CMP_GEZ; c.link_on_taken = 1'b1; end
            FK_BR_LTZ_LNK: begin c.src = SRC_BRANCH; c.cmp = CMP_LTZ; c.link_on_taken = 1'b1; end
            FK_JMP:        begin c.src = SRC_DIRECT; end
            FK_JMP_LNK:    begin c.src = SRC_DIRECT; c.link_always = 1'b1; end
            FK_JREG:       begin c.src = SRC_REG; end
            FK_JREG_LNK:   begin c.src = SRC_REG; c.link_always = 1'b1; c.link_to_rd = 1'b1; end
            default:       ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/npc_cond.sv
module npc_cond
    import npc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  cmp_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic            holds
);
    logic is_neg;
    logic is_zero;

    assign is_neg  = a[XLEN-1];
    assign is_zero = (a == '0);

    always_comb begin
        case (op)
            CMP_EQ:  holds = (a == b);
            CMP_NE:  holds = (a != b);
            CMP_GEZ: holds = !is_neg;
            CMP_GTZ: holds = !is_neg && !is_zero;
            CMP_LEZ: holds = is_neg || is_zero;
            CMP_LTZ: holds = is_neg;
            default: holds = 1'b0;
        endcase
    end
endmodule

// File: rtl/npc_target.sv
module npc_target #(
    parameter int XLEN  = 32,
    parameter int OFF_W = 16,
    parameter int JT_W  = 26
) (
    input  logic [XLEN-1:0]  pc_seq,
    input  logic [OFF_W-1:0] br_offset,
    input  logic [JT_W-1:0]  jump_field,
    output logic [XLEN-1:0]  br_tgt,
    output logic [XLEN-1:0]  jmp_tgt
);
    localparam int EXT_W = XLEN - OFF_W - 2;
    localparam int HI_W  = XLEN - JT_W - 2;

    logic [XLEN-1:0] disp;

    generate
        if (EXT_W > 0) begin : g_sext
            assign disp = {{EXT_W{br_offset[OFF_W-1]}}, br_offset, 2'b00};
        end else begin : g_nosext
            assign disp = {br_offset[XLEN-3:0], 2'b00};
        end

        if (HI_W > 0) begin : g_region
            assign jmp_tgt = {pc_seq[XLEN-1 -: HI_W], jump_field, 2'b00};
        end else begin : g_flat
            assign jmp_tgt = {jump_field[XLEN-3:0], 2'b00};
        end
    endgenerate

    assign br_tgt = pc_seq + disp;
endmodule

// File: rtl/npc_link.sv
module npc_link
    import npc_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int RIDX_W   = 5,
    parameter int LINK_REG = 31
) (
    input  flow_ctl_t         ctl,
    input  logic              cond_true,
    input  logic [RIDX_W-1:0] rd_sel,
    input  logic [XLEN-1:0]   pc_seq,
    output logic              link_we,
    output logic [RIDX_W-1:0] link_sel,
    output logic [XLEN-1:0]   link_addr
);
    localparam logic [RIDX_W-1:0] RA_IDX = RIDX_W'(LINK_REG);

    assign link_we   = ctl.link_always | (ctl.link_on_taken & cond_true);
    assign link_sel  = ctl.link_to_rd ? rd_sel : RA_IDX;
    assign link_addr = pc_seq;
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter int          XLEN       = 32,
    parameter int          OFF_W      = 16,
    parameter int          JT_W       = 26,
    parameter int          RIDX_W     = 5,
    parameter int          LINK_REG   = 31,
    parameter logic [31:0] START_ADDR = 32'h0040_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        flow_kind,
    input  logic [OFF_W-1:0]  br_offset,
    input  logic [JT_W-1:0]   jump_field,
    input  logic [XLEN-1:0]   rs_value,
    input  logic [XLEN-1:0]   cmp_a,
    input  logic [XLEN-1:0]   cmp_b,
    input  logic [RIDX_W-1:0] rd_sel,
    output logic [XLEN-1:0]   pc,
    output logic [XLEN-1:0]   pc_next,
    output logic              redirect,
    output logic              link_we,
    output logic [RIDX_W-1:0] link_sel,
    output logic [XLEN-1:0]   link_addr
);
    localparam logic [XLEN-1:0] STEP  = XLEN'(4);
    localparam logic [XLEN-1:0] RST_PC = XLEN'(START_ADDR);

    flow_ctl_t       ctl;
    logic            cond_true;
    logic [XLEN-1:0] pc_seq;
    logic [XLEN-1:0] br_tgt;
    logic [XLEN-1:0] jmp_tgt;

    assign ctl    = decode_flow(flow_kind);
    assign pc_seq = pc + STEP;

    npc_cond #(.XLEN(XLEN)) cond_i (
        .op    (ctl.cmp),
        .a     (cmp_a),
        .b     (cmp_b),
        .holds (cond_true)
    );

    npc_target #(.XLEN(XLEN), .OFF_W(OFF_W), .JT_W(JT_W)) tgt_i (
        .pc_seq     (pc_seq),
        .br_offset  (br_offset),
        .jump_field (jump_field),
        .br_tgt     (br_tgt),
        .jmp_tgt    (jmp_tgt)
    );

    npc_link #(.XLEN(XLEN), .RIDX_W(RIDX_W), .LINK_REG(LINK_REG)) link_i (
        .ctl       (ctl),
        .cond_true (cond_true),
        .rd_sel    (rd_sel),
        .pc_seq    (pc_seq),
        .link_we   (link_we),
        .link_sel  (link_sel),
        .link_addr (link_addr)
    );

    always_comb begin
        case (ctl.src)
            SRC_BRANCH: begin
                pc_next  = cond_true ? br_tgt : pc_seq;
                redirect = cond_true;
            end
            SRC_DIRECT: begin
                pc_next  = jmp_tgt;
                redirect = 1'b1;
            end
            SRC_REG: begin
                pc_next  = rs_value;
                redirect = 1'b1;
            end
            default: begin
                pc_next  = pc_seq;
                redirect = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) pc <= RST_PC;
        else     pc <= pc_next;
    end

    assert_reset_start_R1: assert property (@(posedge clk)
        rst |=> (pc == RST_PC));

    assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
        (flow_kind == FK_SEQ) |=> (pc == $past(pc) + STEP));

    assert_ne_fallthrough_R4: assert property (@(posedge clk) disable iff (rst)
        (flow_kind == FK_BR_EQ && cmp_a != cmp_b) |=> (pc == $past(pc) + STEP));

    assert_cond_link_gated_R6: assert property (@(posedge clk) disable iff (rst)
        (ctl.link_on_taken && !cond_true) |-> !link_we);

    assert_jump_field_R7: assert property (@(posedge clk) disable iff (rst)
        (flow_kind == FK_JMP) |=> (pc[1:0] == 2'b00 && pc[JT_W+1:2] == $past(jump_field)));

    assert_reg_jump_R9: assert property (@(posedge clk) disable iff (rst)
        (flow_kind == FK_JREG || flow_kind == FK_JREG_LNK) |=> (pc == $past(rs_value)));

endmodule

// File: tb/npc_unit_tb_top.sv
`timescale 1ns/1ps
module npc_unit_tb_top;

    localparam logic [31:0] START = 32'h0FFF_FFF0;
    localparam int NV = 24;

    typedef struct packed {
        logic [3:0]  k;
        logic [15:0] off;
        logic [25:0] jf;
        logic [31:0] rv;
        logic [31:0] a;
        logic [31:0] b;
        logic [4:0]  rd;
    } vec_t;

    typedef struct packed {
        logic [31:0] nxt;
        logic        redir;
        logic        we;
        logic [4:0]  idx;
        logic [31:0] laddr;
    } exp_t;

    localparam vec_t VECS [NV] = '{
        '{4'd0,  16'h0000, 26'h0,       32'h0,         32'h0,         32'h0, 5'd0},
        '{4'd0,  16'h7777, 26'h3FFFFFF, 32'hDEADBEEC,  32'h1,         32'h1, 5'd4},
        '{4'd0,  16'h0000, 26'h0,       32'h0,         32'h0,         32'h0, 5'd0},
        '{4'd9,  16'h0000, 26'h20,      32'h0,         32'h0,         32'h0, 5'd0},
        '{4'd1,  16'h0004, 26'h0,       32'h0,         32'h5,         32'h5, 5'd0},
        '{4'd1,  16'h0004, 26'h0,       32'h0,         32'h5,         32'h6, 5'd0},
        '{4'd2,  16'hFFFE, 26'h0,       32'h0,         32'h1,         32'h2, 5'd0},
        '{4'd2,  16'h0010, 26'h0,       32'h0,         32'h7,         32'h7, 5'd0},
        '{4'd3,  16'h0001, 26'h0,       32'h0,         32'h0,         32'h0, 5'd0},
        '{4'd4,  16'h0008, 26'h0,       32'h0,         32'h0,         32'h0, 5'd0},
        '{4'd4,  16'h0003, 26'h0,       32'h0,         32'h1,         32'h0, 5'd0},
        '{4'd5,  16'h0000, 26'h0,       32'h0,         32'h0,         32'h0, 5'd0},
        '{4'd5,  16'h0002, 26'h0,       32'h0,         32'h8000_0000, 32'h0, 5'd0},
        '{4'd6,  16'h0005, 26'h0,       32'h0,         32'h0,         32'h0, 5'd0},
        '{4'd6,  16'h8000, 26'h0,       32'h0,         32'hFFFF_FFFF, 32'h0, 5'd0},
        '{4'd3,  16'h0007, 26'h0,       32'h0,         32'h8000_0000, 32'h0, 5'd0},
        '{4'd7,  16'h0005, 26'h0,       32'h0,         32'h3,         32'h0, 5'd0},
        '{4'd7,  16'h0005, 26'h0,       32'h0,         32'hFFFF_FFFF, 32'h0, 5'd0},
        '{4'd8,  16'hFFFF, 26'h0,       32'h0,         32'hFFFF_FFFB, 32'h0, 5'd0},
        '{4'd8,  16'h0006, 26'h0,       32'h0,         32'h0,         32'h0, 5'd0},
        '{4'd10, 16'h0000, 26'h3FFFFFF, 32'h0,         32'h0,         32'h0, 5'd0},
        '{4'd11, 16'h1234, 26'h0,       32'h0040_0020, 32'h5,         32'h5, 5'd9},
        '{4'd12, 16'h0000, 26'h0,       32'h1234_5678, 32'h0,         32'h0, 5'd7},
        '{4'd13, 16'h0040, 26'h155,     32'hCAFE_F00C, 32'h1,         32'h1, 5'd3}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  flow_kind = 4'd0;
    logic [15:0] br_offset = '0;
    logic [25:0] jump_field = '0;
    logic [31:0] rs_value = '0;
    logic [31:0] cmp_a = '0;
    logic [31:0] cmp_b = '0;
    logic [4:0]  rd_sel = '0;
    logic [31:0] pc, pc_next, link_addr;
    logic        redirect, link_we;
    logic [4:0]  link_sel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    npc_unit #(.START_ADDR(START)) dut_i (
        .clk(clk), .rst(rst), .flow_kind(flow_kind), .br_offset(br_offset),
        .jump_field(jump_field), .rs_value(rs_value), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .rd_sel(rd_sel), .pc(pc), .pc_next(pc_next), .redirect(redirect),
        .link_we(link_we), .link_sel(link_sel), .link_addr(link_addr)
    );

    function automatic exp_t model(input vec_t v, input logic [31:0] p);
        exp_t e;
        logic [31:0] s;
        logic c;
        s = p + 32'd4;
        e = '{nxt: s, redir: 1'b0, we: 1'b0, idx: 5'd31, laddr: s};
        case (v.k)
            4'd1:       c = (v.a == v.b);
            4'd2:       c = (v.a != v.b);
            4'd3, 4'd7: c = !v.a[31];
            4'd4:       c = !v.a[31] && (v.a != 0);
            4'd5:       c = v.a[31] || (v.a == 0);
            4'd6, 4'd8: c = v.a[31];
            default:    c = 1'b0;
        endcase
        if (v.k >= 4'd1 && v.k <= 4'd8 && c) begin
            e.nxt   = s + {{14{v.off[15]}}, v.off, 2'b00};
            e.redir = 1'b1;
            e.we    = (v.k == 4'd7 || v.k == 4'd8);
        end
        if (v.k == 4'd9 || v.k == 4'd10) begin
            e.nxt   = {s[31:28], v.jf, 2'b00};
            e.redir = 1'b1;
            e.we    = (v.k == 4'd10);
        end
        if (v.k == 4'd11 || v.k == 4'd12) begin
            e.nxt   = v.rv;
            e.redir = 1'b1;
            if (v.k == 4'd12) begin
                e.we  = 1'b1;
                e.idx = v.rd;
            end
        end
        return e;
    endfunction

    function automatic string req_of(input logic [3:0] k);
        case (k)
            4'd0:         return "R2";
            4'd1, 4'd2:   return "R4";
            4'd3, 4'd4,
            4'd5, 4'd6:   return "R5";
            4'd7, 4'd8:   return "R6";
            4'd9:         return "R7";
            4'd10:        return "R8";
            4'd11, 4'd12: return "R9";
            default:      return "R11";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        flow_kind  = v.k;
        br_offset  = v.off;
        jump_field = v.jf;
        rs_value   = v.rv;
        cmp_a      = v.a;
        cmp_b      = v.b;
        rd_sel     = v.rd;
    endtask

    initial begin : watchdog
        #100000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] exp_pc;
        exp_t e;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "pc after reset", pc, START);
        rst = 1'b0;
        exp_pc = START;

        // table walk: R2 R3 R4 R5 R6 R7 R8 R9 R10 R11
        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            #1;
            e = model(VECS[i], exp_pc);
            check(req_of(VECS[i].k), "pc_next", pc_next, e.nxt);
            check("R10", "redirect", {31'b0, redirect}, {31'b0, e.redir});
            check(req_of(VECS[i].k), "link_we", {31'b0, link_we}, {31'b0, e.we});
            check("R10", "link_sel", {27'b0, link_sel}, {27'b0, e.idx});
            if (e.we)
                check(req_of(VECS[i].k), "link_addr", link_addr, e.laddr);
            exp_pc = e.nxt;
            @(negedge clk);
            check(req_of(VECS[i].k), "pc", pc, exp_pc);
        end

        // R1: reset wins over a pending jump
        apply('{4'd9, 16'h0, 26'h1234, 32'h0, 32'h0, 32'h0, 5'd0});
        rst = 1'b1;
        @(negedge clk);
        check("R1", "pc after mid-run reset", pc, START);
        rst = 1'b0;

        // R3: largest positive displacement from START
        apply('{4'd2, 16'h7FFF, 26'h0, 32'h0, 32'h0, 32'h1, 5'd0});
        #1;
        check("R3", "pc_next max offset", pc_next, 32'h1001_FFF0);
        @(negedge clk);
        check("R3", "pc max offset", pc, 32'h1001_FFF0);

        // R11: unused code 15 with all other inputs busy
        apply('{4'd15, 16'hFFFF, 26'h3FFFFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 5'd1});
        #1;
        check("R11", "pc_next code 15", pc_next, 32'h1001_FFF4);
        check("R11", "link_we code 15", {31'b0, link_we}, 32'h0);
        @(negedge clk);
        check("R11", "pc code 15", pc, 32'h1001_FFF4);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule